// File: doc/BRIEF.md
# Cascadable Nibble-Serial Line Loader

This block gathers one display line of 80 columns from a 4-bit data bus shared by several identical devices. Every falling edge of the shift clock can move one nibble into the line. The devices form a chain: each one loads only while its active-low enable input is low. When its line is full, it drives its enable output low, so the next device in the chain starts to take the bus. A line-latch pulse re-arms every device in the chain at once.

A direction select sets two things. It sets the order in which nibbles fill the columns, and it sets which of the two enable pins is the input and which is the output. Each bidirectional enable pin is modelled as three separate ports: input, output and output-enable. When the last nibble arrives, the completed line is copied into a holding register that a downstream write stage reads. A one-cycle completion strobe marks the copy.

A three-state controller sequences the block; all of its registers change on the falling edge of the shift clock.

| State | Meaning |
|---|---|
| ST_WAIT | Armed with no nibbles taken yet |
| ST_LOAD | Part of the line has been loaded |
| ST_FULL | All nibbles have been taken |

The controller has these transitions:

- **T_LAT**: any state goes to ST_WAIT on a latch edge.
- **T_FIRST**: ST_WAIT goes to ST_LOAD on a capture.
- **T_NEXT**: ST_LOAD stays in ST_LOAD on a capture that is not the last.
- **T_LAST**: ST_WAIT or ST_LOAD goes to ST_FULL on the 20th capture.
- **T_HOLD**: the state does not change when no capture occurs.

Top module: `nib_chain_loader`

## Requirements
- R1: While reset is held low, and after it is released:
  - the state is ST_WAIT;
  - the enable output is high;
  - `line_out` is all zeros;
  - `line_done` is 0.
- R2: With `dir` = 0, nibble n (numbered from 0) places `din[3]`, `din[2]`, `din[1]`, `din[0]` in columns 80-4n, 79-4n, 78-4n and 77-4n. Column c is `line_out[c-1]`.
- R3: With `dir` = 1, nibble n places `din[3]`, `din[2]`, `din[1]`, `din[0]` in columns 4n+1, 4n+2, 4n+3 and 4n+4.
- R4: The pin roles follow `dir`:
  - With `dir` = 0, pin 1 is the output (`eio1_oe`=1, `eio2_oe`=0) and the enable input is read from `eio2_in`.
  - With `dir` = 1, the roles swap (`eio2_oe`=1, `eio1_oe`=0) and the enable input is read from `eio1_in`.
  - Both `eio*_out` ports carry the enable output value.
- R5: A falling shift-clock edge captures a nibble only when the enable input is low. An edge with the enable input high is ignored.
- R6: After the 20th capture, the enable output goes low. Further edges are ignored until a latch: `line_out` is unchanged and `line_done` stays 0.
- R7: `line_done` is high for exactly the one cycle after the edge that captured the 20th nibble. `line_out` takes the new line at that same edge and changes at no other time.
- R8: An edge with `lat` = 1 has these effects:
  - no nibble is captured;
  - the controller returns to ST_WAIT with zero nibbles counted;
  - the enable output goes high;
  - `line_out` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Shift clock; the falling edge is active |
| din | input | 4 | Nibble data bus |
| lat | input | 1 | Line-latch pulse, sampled on the falling edge |
| dir | input | 1 | Direction and pin-role select |
| eio1_in | input | 1 | Enable pin 1, input side |
| eio1_out | output | 1 | Enable pin 1, driven value |
| eio1_oe | output | 1 | Enable pin 1, output enable |
| eio2_in | input | 1 | Enable pin 2, input side |
| eio2_out | output | 1 | Enable pin 2, driven value |
| eio2_oe | output | 1 | Enable pin 2, output enable |
| line_out | output | 80 | Completed line; bit c-1 is column c |
| line_done | output | 1 | One-cycle line-complete strobe |

## Verification
A nibble counter that is off by one does not show up while the line is loading. It shows one edge later: the enable output falls early or late, `line_done` pulses on the wrong cycle, and `line_out` shows every column shifted by four. A wrong shift direction or wrong bit order scrambles `line_out`, which is compared in full when each line completes. A controller that misses a latch, or that captures after filling, holds the enable output wrong or disturbs `line_out` on the next edge.

// File: rtl/nib_loader_pkg.sv
package nib_loader_pkg;
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_LOAD = 2'd1,
        ST_FULL = 2'd2
    } ld_state_t;
endpackage

// File: rtl/nib_loader_fsm.sv
module nib_loader_fsm
    import nib_loader_pkg::*;
#(
    parameter int NIB = 20
) (
    input  logic rst_n,
    input  logic sclk,
    input  logic lat,
    input  logic ein_n,
    output logic cap_o,
    output logic last_o,
    output logic eout_o,
    output logic done_o
);
    localparam int CW = $clog2(NIB + 1);
    localparam logic [CW-1:0] LAST_IDX = CW'(NIB - 1);

    ld_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic done_d;

    // outputs of the controller
    always_comb begin
        cap_o  = 1'b0;
        eout_o = 1'b1;
        unique case (state_q)
            ST_WAIT, ST_LOAD: cap_o = !lat && !ein_n;
            ST_FULL:          eout_o = 1'b0;
            default:          cap_o = 1'b0;
        endcase
        last_o = cap_o && (cnt_q == LAST_IDX);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        done_d  = 1'b0;
        if (lat) begin
            state_d = ST_WAIT;
            cnt_d   = '0;
        end else if (cap_o) begin
            cnt_d = cnt_q + 1'b1;
            if (last_o) begin
                state_d = ST_FULL;
                done_d  = 1'b1;
            end else begin
                state_d = ST_LOAD;
            end
        end
    end

    // state register
    always_ff @(negedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            cnt_q   <= '0;
            done_o  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            done_o  <= done_d;
        end
    end

    // R8
    lat_rearm_chk: assert property (@(negedge sclk) disable iff (!rst_n)
        lat |=> (eout_o && cnt_q == '0 && state_q == ST_WAIT));
    // R5
    idle_enable_chk: assert property (@(negedge sclk) disable iff (!rst_n)
        (ein_n && !lat) |=> $stable(cnt_q));
    // R6
    eout_fall_chk: assert property (@(negedge sclk) disable iff (!rst_n)
        $fell(eout_o) |-> done_o);
    // R7
    done_pulse_chk: assert property (@(negedge sclk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/nib_line_shreg.sv
module nib_line_shreg #(
    parameter int COLS = 80,
    parameter int DW   = 4
) (
    input  logic            rst_n,
    input  logic            sclk,
    input  logic [DW-1:0]   din,
    input  logic            dir,
    input  logic            cap,
    input  logic            last,
    input  logic            done_i,
    output logic [COLS-1:0] line_out
);
    logic [COLS-1:0] sh_q, sh_d;
    logic [DW-1:0]   din_rev;

    genvar gi;
    generate
        for (gi = 0; gi < DW; gi++) begin : g_rev
            assign din_rev[gi] = din[DW-1-gi];
        end
    endgenerate

    always_comb begin
        if (dir) sh_d = {din_rev, sh_q[COLS-1:DW]};
        else     sh_d = {sh_q[COLS-DW-1:0], din};
    end

    always_ff @(negedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q     <= '0;
            line_out <= '0;
        end else begin
            if (cap)  sh_q     <= sh_d;
            if (last) line_out <= sh_d;
        end
    end

    // R7
    line_hold_chk: assert property (@(negedge sclk) disable iff (!rst_n)
        !$stable(line_out) |-> done_i);
endmodule

// File: rtl/nib_chain_loader.sv
module nib_chain_loader #(
    parameter int COLS = 80,
    parameter int DW   = 4
) (
    input  logic            rst_n,
    input  logic            sclk,
    input  logic [DW-1:0]   din,
    input  logic            lat,
    input  logic            dir,
    input  logic            eio1_in,
    output logic            eio1_out,
    output logic            eio1_oe,
    input  logic            eio2_in,
    output logic            eio2_out,
    output logic            eio2_oe,
    output logic [COLS-1:0] line_out,
    output logic            line_done
);
    localparam int NIB = COLS / DW;

    logic ein_n, cap, last, eout;

    assign ein_n    = dir ? eio1_in : eio2_in;
    assign eio1_oe  = !dir;
    assign eio2_oe  = dir;
    assign eio1_out = eout;
    assign eio2_out = eout;

    nib_loader_fsm #(.NIB(NIB)) u_fsm (
        .rst_n (rst_n),
        .sclk  (sclk),
        .lat   (lat),
        .ein_n (ein_n),
        .cap_o (cap),
        .last_o(last),
        .eout_o(eout),
        .done_o(line_done)
    );

    nib_line_shreg #(.COLS(COLS), .DW(DW)) u_shreg (
        .rst_n   (rst_n),
        .sclk    (sclk),
        .din     (din),
        .dir     (dir),
        .cap     (cap),
        .last    (last),
        .done_i  (line_done),
        .line_out(line_out)
    );

    // R4
    pin_role_chk: assert property (@(negedge sclk) disable iff (!rst_n)
        (eio1_oe != eio2_oe) && (eio1_out == eio2_out));
endmodule

// File: tb/nib_chain_loader_tb.sv
module nib_chain_loader_tb;
    localparam int PERIOD = 10;

    logic rst_n, sclk, lat, dir, eio1_in, eio2_in;
    logic [3:0] din;
    logic eio1_out, eio1_oe, eio2_out, eio2_oe, line_done;
    logic [79:0] line_out;

    int n_chk, n_bad;
    logic [3:0] nib [20];
    logic [79:0] held;

    nib_chain_loader u_dut (
        .rst_n(rst_n), .sclk(sclk), .din(din), .lat(lat), .dir(dir),
        .eio1_in(eio1_in), .eio1_out(eio1_out), .eio1_oe(eio1_oe),
        .eio2_in(eio2_in), .eio2_out(eio2_out), .eio2_oe(eio2_oe),
        .line_out(line_out), .line_done(line_done)
    );

    initial sclk = 1'b0;
    always #(PERIOD/2) sclk = ~sclk;

    function automatic logic [79:0] exp_line(input logic d);
        logic [79:0] v = '0;
        for (int n = 0; n < 20; n++)
            for (int b = 0; b < 4; b++)
                if (d) v[4*n + (3-b)] = nib[n][b];
                else   v[76 - 4*n + b] = nib[n][b];
        return v;
    endfunction

    task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic eout_pin();
        return dir ? eio2_out : eio1_out;
    endfunction

    // drive one edge: enable input active-low; the opposite pin gets the inverse
    task automatic step(input logic [3:0] d, input logic en_n, input logic l);
        din = d; lat = l;
        if (dir) begin eio1_in = en_n; eio2_in = ~en_n; end
        else     begin eio2_in = en_n; eio1_in = ~en_n; end
        @(posedge sclk); #1;
    endtask

    initial begin
        #(PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog act=hung exp=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1957));
        n_chk = 0; n_bad = 0;
        rst_n = 0; din = 0; lat = 0; dir = 0; eio1_in = 1; eio2_in = 1;
        repeat (3) @(posedge sclk);
        #1;
        chk("R1 eout", 80'(eio1_out), 80'(1));
        chk("R1 done", 80'(line_done), 80'(0));
        chk("R1 line", line_out, '0);
        rst_n = 1;
        step(4'h0, 1'b1, 1'b0);
        chk("R1 line after release", line_out, '0);
        held = '0;

        for (int ln = 0; ln < 40; ln++) begin
            logic use_dir;
            int got;
            use_dir = (ln < 2) ? ln[0] : 1'($urandom);
            dir = use_dir;
            step(4'h0, 1'b0, 1'b1);
            // R8: latch re-arms, takes nothing, keeps the held line
            chk("R8 eout high", 80'(eout_pin()), 80'(1));
            chk("R8 line kept", line_out, held);
            chk("R4 oe", 80'({eio1_oe, eio2_oe}), dir ? 80'(2'b01) : 80'(2'b10));
            got = 0;
            while (got < 20) begin
                logic [3:0] d;
                logic gap;
                d = 4'($urandom);
                gap = ($urandom % 4) == 0;
                step(d, gap, 1'b0);
                if (!gap) begin nib[got] = d; got++; end
                if (got < 20) begin
                    // R5: enable input gates capture; no early completion
                    chk("R5 no early done", 80'(line_done), 80'(0));
                    chk("R6 eout still high", 80'(eout_pin()), 80'(1));
                end
            end
            held = exp_line(dir);
            chk(dir ? "R3 line map" : "R2 line map", line_out, held);
            chk("R7 done pulse", 80'(line_done), 80'(1));
            chk("R6 eout low", 80'(eout_pin()), 80'(0));
            for (int k = 0; k < 1 + ln % 3; k++) begin
                step(4'($urandom), 1'b0, 1'b0);
                chk("R7 done one cycle", 80'(line_done), 80'(0));
                chk("R6 ignored after full", line_out, held);
            end
        end

        // directed: dir=0 first nibble 0x8 alone sets column 80
        dir = 0;
        step(4'h0, 1'b0, 1'b1);
        for (int n = 0; n < 20; n++) begin
            nib[n] = (n == 0) ? 4'h8 : 4'h0;
            step(nib[n], 1'b0, 1'b0);
        end
        chk("R2 column 80", line_out, 80'(1) << 79);
        // directed: dir=1 first nibble 0x8 alone sets column 1
        dir = 1;
        step(4'h0, 1'b0, 1'b1);
        for (int n = 0; n < 20; n++) step(nib[n], 1'b0, 1'b0);
        chk("R3 column 1", line_out, 80'(1));

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule